// File: doc/BRIEF.md
# Convolutional Byte Deinterleaver

This block undoes a convolutional byte interleave of the type in which a commutator deals bytes over I parallel delay lines. In the interleaver, line j holds its bytes for j·M visits. The deinterleaver gives line j a delay of (I-1-j)·M visits, so every byte leaves after the same end-to-end delay of (I-1)·L byte slots. L is the block length and M = L / I is the unit delay. The block reorders bytes and never alters a value.

All delay lines share one internal circular memory. Each line owns a contiguous region of that memory, whose base and length are derived from the configured depth and block length, plus its own rotating pointer. A start-of-block marker on the input locks the commutator to line 0. While the block stays locked, markers that fall on a block boundary pass without effect. A marker in any other position restarts the commutator, the pointers and the fill count. A bypass setting hands bytes straight through. The depth may be set from 1 to 16 and the block length from 34 to 255 bytes. The block length must be a whole multiple of the depth.

Top module: `dlv_deinterleaver`

## Requirements
- R1: While reset is held and in the cycle after it is released, out_valid, out_sop and out_data are all zero.
- R2: After reset, input bytes accepted before the first start marker (in_sop high with in_valid) produce no output (out_valid stays 0).
- R3: In the deinterleaving mode, the k-th byte accepted since the last resynchronisation (k = 0 is the marked byte) produces out_data equal to the byte the interleaver received at stream position k-(I-1)·L, exactly one clock after it is accepted.
- R4: out_valid is high one clock after each accepted byte whose index k is at least (I-1)·L, and low after every other byte. A cycle with in_valid low produces out_valid low and does not advance the commutator.
- R5: out_sop is high exactly with the valid output bytes whose index k is a multiple of L.
- R6: A start marker that arrives while the block is locked, with the commutator on line 0 and the byte count within the block at 0, has no effect. A marker in any other position restarts the process at k = 0 and blanks the output again for (I-1)·L bytes.
- R7: With depth 1, every byte accepted from the start marker on appears unchanged and valid one clock later.
- R8: With cfg_bypass high, out_valid, out_sop and out_data equal in_valid, in_sop and in_data of the previous clock.
- R9: The largest configuration (depth 16, block length 240) deinterleaves correctly while idle cycles are interleaved with the input bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_depth | input | 5 | Interleave depth I (1..16) |
| cfg_blk_len | input | 8 | Block length L in bytes (34..255, multiple of I) |
| cfg_bypass | input | 1 | High: pass bytes through unchanged |
| in_valid | input | 1 | Input byte strobe |
| in_sop | input | 1 | Start-of-block marker on the input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte strobe |
| out_sop | output | 1 | First byte of a deinterleaved block |
| out_data | output | 8 | Output byte |

## Verification
Under the locked, continuous flow, a start marker on a block boundary and a commutator wrap back to line 0 land on the same byte. That same byte is also a read and a write of line 0's region at a single address. The bench provokes this by sending a marker with every block over several blocks. It judges the result by requiring that out_valid never drops and that each output byte matches the original stream. A second case sends a marker when the commutator is off line 0. It is judged by the return of blanking for exactly (I-1)·L bytes and by realignment to the new origin.

// File: rtl/dlv_pkg.sv
package dlv_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // One registered output beat.
    typedef struct packed {
        logic  valid;
        logic  sop;
        byte_t data;
    } beat_t;

    // Depth values outside 1..max_d are folded into that range.
    function automatic int clamp_depth(input int d, input int max_d);
        if (d < 1) begin
            return 1;
        end
        if (d > max_d) begin
            return max_d;
        end
        return d;
    endfunction

    // Start of line j's region: sum of the lengths of lines 0..j-1.
    function automatic int branch_base(input int j, input int depth, input int unit);
        if (j >= depth) begin
            return 0;
        end
        return unit * (j * (depth - 1) - (j * (j - 1)) / 2);
    endfunction

    // Delay of line j in visits of that line.
    function automatic int branch_len(input int j, input int depth, input int unit);
        if (j >= depth) begin
            return 0;
        end
        return (depth - 1 - j) * unit;
    endfunction

endpackage

// File: rtl/dlv_geometry.sv
module dlv_geometry #(
    parameter int MAX_DEPTH = 16,
    parameter int LEN_W     = 8,
    parameter int DEP_W     = 5,
    parameter int ADDR_W    = 11,
    parameter int PTR_W     = 8,
    parameter int CNT_W     = 12
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [DEP_W-1:0]                  cfg_depth,
    input  logic [LEN_W-1:0]                  cfg_blk_len,
    output logic [DEP_W-1:0]                  depth_q,
    output logic [LEN_W-1:0]                  blk_len_q,
    output logic [MAX_DEPTH-1:0][ADDR_W-1:0]  base_q,
    output logic [MAX_DEPTH-1:0][PTR_W-1:0]   len_q,
    output logic [CNT_W-1:0]                  fill_q
);

    int dep_i;
    int unit_i;

    logic [MAX_DEPTH-1:0][ADDR_W-1:0] base_n;
    logic [MAX_DEPTH-1:0][PTR_W-1:0]  len_n;
    logic [CNT_W-1:0]                 fill_n;

    always_comb begin
        dep_i  = dlv_pkg::clamp_depth(int'(cfg_depth), MAX_DEPTH);
        unit_i = int'(cfg_blk_len) / dep_i;
        fill_n = CNT_W'((dep_i - 1) * int'(cfg_blk_len));
    end

    for (genvar j = 0; j < MAX_DEPTH; j++) begin : g_branch
        assign base_n[j] = ADDR_W'(dlv_pkg::branch_base(j, dep_i, unit_i));
        assign len_n[j]  = PTR_W'(dlv_pkg::branch_len(j, dep_i, unit_i));
    end

    // One register stage keeps the divider and multipliers off the byte path.
    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q   <= DEP_W'(1);
            blk_len_q <= '0;
            base_q    <= '0;
            len_q     <= '0;
            fill_q    <= '0;
        end else begin
            depth_q   <= DEP_W'(dep_i);
            blk_len_q <= cfg_blk_len;
            base_q    <= base_n;
            len_q     <= len_n;
            fill_q    <= fill_n;
        end
    end

endmodule

// File: rtl/dlv_commutator.sv
module dlv_commutator #(
    parameter int LEN_W = 8,
    parameter int DEP_W = 5,
    parameter int BR_W  = 4,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             sop,
    input  logic [DEP_W-1:0] depth_q,
    input  logic [LEN_W-1:0] blk_len_q,
    input  logic [CNT_W-1:0] fill_q,
    output logic [BR_W-1:0]  cur_branch,
    output logic             resync,
    output logic             advance,
    output logic             emit,
    output logic             block_start,
    output logic             locked_q
);

    logic [BR_W-1:0]  br_q;
    logic [LEN_W-1:0] pos_q;
    logic [CNT_W-1:0] cnt_q;
    logic [LEN_W-1:0] cur_pos;
    logic [CNT_W-1:0] cur_cnt;
    logic [BR_W-1:0]  last_br;

    // A marker restarts unless it lands where a locked stream expects one.
    assign resync      = accept && sop && (!locked_q || (br_q != '0) || (pos_q != '0));
    assign advance     = accept && (locked_q || resync);
    assign cur_branch  = resync ? '0 : br_q;
    assign cur_pos     = resync ? '0 : pos_q;
    assign cur_cnt     = resync ? '0 : cnt_q;
    assign last_br     = BR_W'(depth_q - 1'b1);
    assign emit        = advance && (cur_cnt >= fill_q);
    assign block_start = (cur_pos == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
            br_q     <= '0;
            pos_q    <= '0;
            cnt_q    <= '0;
        end else if (advance) begin
            locked_q <= 1'b1;
            br_q     <= (cur_branch == last_br) ? '0 : cur_branch + 1'b1;
            pos_q    <= (cur_pos == blk_len_q - 1'b1) ? '0 : cur_pos + 1'b1;
            cnt_q    <= (cur_cnt >= fill_q) ? cur_cnt : cur_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dlv_delay_store.sv
module dlv_delay_store #(
    parameter int MAX_DEPTH = 16,
    parameter int MEM_DEPTH = 1912,
    parameter int ADDR_W    = 11,
    parameter int PTR_W     = 8,
    parameter int BR_W      = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              advance,
    input  logic                              clear,
    input  logic [BR_W-1:0]                   branch,
    input  dlv_pkg::byte_t                    din,
    input  logic [MAX_DEPTH-1:0][ADDR_W-1:0]  base_q,
    input  logic [MAX_DEPTH-1:0][PTR_W-1:0]   len_q,
    output dlv_pkg::byte_t                    dout
);

    dlv_pkg::byte_t mem [MEM_DEPTH];

    logic [MAX_DEPTH-1:0][PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0]                ptr_cur;
    logic [PTR_W-1:0]                len_cur;
    logic [ADDR_W-1:0]               addr;
    logic                            zero_delay;

    assign ptr_cur    = clear ? '0 : ptr_q[branch];
    assign len_cur    = len_q[branch];
    assign zero_delay = (len_cur == '0);
    assign addr       = base_q[branch] + ADDR_W'(ptr_cur);

    // Read the oldest entry, then overwrite it with the new byte.
    assign dout = zero_delay ? din : mem[addr];

    always_ff @(posedge clk) begin
        if (advance && !zero_delay) begin
            mem[addr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (advance) begin
            if (clear) begin
                for (int i = 0; i < MAX_DEPTH; i++) begin
                    ptr_q[i] <= '0;
                end
            end
            if (!zero_delay) begin
                ptr_q[branch] <= (ptr_cur == len_cur - 1'b1) ? '0 : ptr_cur + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dlv_deinterleaver.sv
module dlv_deinterleaver #(
    parameter int MAX_DEPTH = 16,
    parameter int LEN_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(MAX_DEPTH+1)-1:0] cfg_depth,
    input  logic [LEN_W-1:0]             cfg_blk_len,
    input  logic                         cfg_bypass,
    input  logic                         in_valid,
    input  logic                         in_sop,
    input  logic [7:0]                   in_data,
    output logic                         out_valid,
    output logic                         out_sop,
    output logic [7:0]                   out_data
);

    localparam int DEP_W     = $clog2(MAX_DEPTH + 1);
    localparam int BR_W      = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;
    localparam int MAX_LEN   = (1 << LEN_W) - 1;
    localparam int MEM_DEPTH = (MAX_LEN * (MAX_DEPTH - 1)) / 2 + 1;
    localparam int ADDR_W    = $clog2(MEM_DEPTH);
    localparam int PTR_W     = LEN_W;
    localparam int CNT_W     = $clog2(MAX_LEN * (MAX_DEPTH - 1) + 1);

    logic [DEP_W-1:0]                 depth_q;
    logic [LEN_W-1:0]                 blk_len_q;
    logic [MAX_DEPTH-1:0][ADDR_W-1:0] base_q;
    logic [MAX_DEPTH-1:0][PTR_W-1:0]  len_q;
    logic [CNT_W-1:0]                 fill_q;

    logic [BR_W-1:0] cur_branch;
    logic            resync_w;
    logic            advance;
    logic            emit;
    logic            block_start;
    logic            lock_w;
    logic            accept;

    dlv_pkg::byte_t delayed;
    dlv_pkg::beat_t out_q;
    dlv_pkg::beat_t out_n;

    assign accept = in_valid && !cfg_bypass;

    dlv_geometry #(
        .MAX_DEPTH(MAX_DEPTH), .LEN_W(LEN_W), .DEP_W(DEP_W),
        .ADDR_W(ADDR_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
    ) u_geom (
        .clk(clk), .rst(rst),
        .cfg_depth(cfg_depth), .cfg_blk_len(cfg_blk_len),
        .depth_q(depth_q), .blk_len_q(blk_len_q),
        .base_q(base_q), .len_q(len_q), .fill_q(fill_q)
    );

    dlv_commutator #(
        .LEN_W(LEN_W), .DEP_W(DEP_W), .BR_W(BR_W), .CNT_W(CNT_W)
    ) u_comm (
        .clk(clk), .rst(rst),
        .accept(accept), .sop(in_sop),
        .depth_q(depth_q), .blk_len_q(blk_len_q), .fill_q(fill_q),
        .cur_branch(cur_branch), .resync(resync_w), .advance(advance),
        .emit(emit), .block_start(block_start), .locked_q(lock_w)
    );

    dlv_delay_store #(
        .MAX_DEPTH(MAX_DEPTH), .MEM_DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W),
        .PTR_W(PTR_W), .BR_W(BR_W)
    ) u_store (
        .clk(clk), .rst(rst),
        .advance(advance), .clear(resync_w), .branch(cur_branch),
        .din(in_data), .base_q(base_q), .len_q(len_q),
        .dout(delayed)
    );

    always_comb begin
        out_n = out_q;
        if (cfg_bypass) begin
            out_n.valid = in_valid;
            out_n.sop   = in_valid && in_sop;
            if (in_valid) begin
                out_n.data = in_data;
            end
        end else begin
            out_n.valid = emit;
            out_n.sop   = emit && block_start;
            if (emit) begin
                out_n.data = delayed;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_n;
        end
    end

    assign out_valid = out_q.valid;
    assign out_sop   = out_q.sop;
    assign out_data  = out_q.data;

endmodule

// File: rtl/dlv_checker.sv
module dlv_checker #(
    parameter int DEP_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [DEP_W-1:0] cfg_depth,
    input logic             cfg_bypass,
    input logic             in_valid,
    input logic             in_sop,
    input logic [7:0]       in_data,
    input logic             out_valid,
    input logic             out_sop,
    input logic [7:0]       out_data,
    input logic             locked,
    input logic             resync
);

    // R4: an output strobe always answers an input strobe one clock earlier.
    p_valid_follows_input_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R5: a block start is only ever flagged on a valid byte.
    p_sop_needs_valid_r5: assert property (@(posedge clk) disable iff (rst)
        out_sop |-> out_valid);

    // R8: bypass reproduces the previous input beat.
    p_bypass_copy_r8: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_bypass) |-> (out_valid == $past(in_valid))
                              && (!out_valid || out_data == $past(in_data)));

    // R2: without lock, and without a marker, nothing is emitted.
    p_quiet_until_lock_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(!locked) && $past(!in_sop) && $past(!cfg_bypass)) |-> !out_valid);

    // R6: a restart with depth above one blanks the next output.
    p_restart_blanks_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(resync) && $past(cfg_depth) > 1 && $past(!cfg_bypass)) |-> !out_valid);

    // R7: depth one is a plain one-clock copy once emitted.
    p_depth_one_copy_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(cfg_depth) == 1) |-> out_data == $past(in_data));

endmodule

bind dlv_deinterleaver dlv_checker #(.DEP_W($clog2(MAX_DEPTH + 1))) u_chk (
    .clk(clk), .rst(rst),
    .cfg_depth(cfg_depth), .cfg_bypass(cfg_bypass),
    .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data),
    .locked(lock_w), .resync(resync_w)
);

// File: tb/dlv_deinterleaver_bench.sv
module dlv_deinterleaver_bench;

    logic       clk;
    logic       rst;
    logic [4:0] cfg_depth;
    logic [7:0] cfg_blk_len;
    logic       cfg_bypass;
    logic       in_valid;
    logic       in_sop;
    logic [7:0] in_data;
    logic       out_valid;
    logic       out_sop;
    logic [7:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Expectation for the beat driven in the previous cycle.
    bit         pend = 0;
    bit         exp_v;
    bit         exp_s;
    logic [7:0] exp_d;
    string      vtag;

    dlv_deinterleaver u_dlv_deinterleaver (
        .clk(clk), .rst(rst),
        .cfg_depth(cfg_depth), .cfg_blk_len(cfg_blk_len), .cfg_bypass(cfg_bypass),
        .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
        .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data)
    );

    initial clk = 0;
    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sgen(input int n);
        return 8'((n * 29) + (n >> 8) * 7 + 3);
    endfunction

    // One cycle: check the pending beat, then drive a new one.
    task automatic step(input bit v, input bit s, input logic [7:0] d,
                        input bit ev, input bit es, input logic [7:0] ed,
                        input string vt);
        @(negedge clk);
        if (pend) begin
            chk(out_valid == exp_v, vtag, int'(out_valid), int'(exp_v));
            chk(out_sop == exp_s, "R5", int'(out_sop), int'(exp_s));
            if (exp_v) begin
                chk(out_data == exp_d, "R3", int'(out_data), int'(exp_d));
            end
        end
        in_valid = v;
        in_sop   = s;
        in_data  = d;
        pend  = 1;
        exp_v = ev;
        exp_s = es;
        exp_d = ed;
        vtag  = vt;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            step(0, 0, 8'h00, 0, 0, 8'h00, "R4");
        end
    endtask

    task automatic do_reset();
        rst = 1;
        in_valid = 0; in_sop = 0; in_data = 0;
        cfg_bypass = 0;
        pend = 0;
        repeat (3) @(negedge clk);
        // R1: outputs are zero during reset
        chk(out_valid == 0 && out_sop == 0 && out_data == 0, "R1",
            int'({out_valid, out_sop, out_data}), 0);
        rst = 0;
        @(negedge clk);
        chk(out_valid == 0 && out_sop == 0 && out_data == 0, "R1",
            int'({out_valid, out_sop, out_data}), 0);
    endtask

    // Feed an interleaved stream that starts with a marker at k = 0 and check
    // the reconstructed stream (R3, R4, R5); gap > 0 adds idle cycles.
    task automatic run_stream(input int dep, input int len, input int nbytes, input int gap);
        int unit = len / dep;
        int fill = (dep - 1) * len;
        cfg_depth   = 5'(dep);
        cfg_blk_len = 8'(len);
        idle(2);
        for (int k = 0; k < nbytes; k++) begin
            int j   = k % dep;
            int src = k - j * unit * dep;
            logic [7:0] d = (src >= 0) ? sgen(src) : 8'hEE;
            bit ev = (k >= fill);
            bit es = ev && (k % len == 0);
            logic [7:0] ed = ev ? sgen(k - fill) : 8'h00;
            step(1, (k % len == 0), d, ev, es, ed, "R4");
            if (gap > 0 && (k % gap) == gap - 1) begin
                idle(1);
            end
        end
        idle(1);
    endtask

    task automatic test_reset();
        do_reset();
    endtask

    task automatic test_no_lock();
        // R2: bytes before the first marker are dropped
        do_reset();
        cfg_depth = 5'd4; cfg_blk_len = 8'd36;
        idle(2);
        for (int i = 0; i < 6; i++) begin
            step(1, 0, 8'(i + 1), 0, 0, 8'h00, "R2");
        end
        idle(1);
        run_stream(4, 36, 36 * 5, 0);
    endtask

    task automatic test_main_depth12();
        // R3 R4 R5, with aligned markers on every block (R6: no effect)
        do_reset();
        run_stream(12, 204, 11 * 204 + 3 * 204, 0);
    endtask

    task automatic test_max_with_gaps();
        // R9: largest depth with idle cycles between bytes
        do_reset();
        run_stream(16, 240, 15 * 240 + 2 * 240, 5);
    endtask

    task automatic test_depth_one();
        // R7: zero delay, valid from the marker on
        do_reset();
        run_stream(1, 34, 100, 0);
    endtask

    task automatic test_misaligned_marker();
        // R6: a marker off line 0 restarts and blanks again
        do_reset();
        run_stream(4, 36, 150, 0);
        run_stream(4, 36, 3 * 36 + 2 * 36, 0);
    endtask

    task automatic test_bypass();
        // R8: bypass copies the input beat one clock later
        do_reset();
        cfg_bypass = 1;
        for (int i = 0; i < 20; i++) begin
            bit v = (i % 3) != 2;
            bit s = (i % 7) == 0;
            logic [7:0] d = sgen(i + 500);
            step(v, s, d, v, v && s, d, "R8");
        end
        idle(1);
        cfg_bypass = 0;
    endtask

    initial begin
        cfg_depth = 5'd4; cfg_blk_len = 8'd36;
        test_reset();
        test_no_lock();
        test_main_depth12();
        test_max_with_gaps();
        test_depth_one();
        test_misaligned_marker();
        test_bypass();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule